// File: doc/BRIEF.md
# GF(3^97) Cubing Unit

This block raises one element of the ternary extension field GF(3^97) to the third power, reduced modulo the fixed trinomial x^97 + x^16 + 2. An element is a polynomial of degree below 97 whose coefficients are base-3 digits. Each digit travels on two wires. Because cubing is linear in characteristic three, the unit does no multiplication. It moves each input digit from position i to position 3i, then folds every position at or above 97 back into the low range with hard-wired substitution terms. It is intended as a building block inside a pairing-style arithmetic datapath, where cubes are needed every cycle.

The arithmetic core is purely combinational and contains no storage. A thin wrapper can place an output register and a valid flag after the core, so the unit fits a pipelined datapath without changing the core. The parameter `OUT_REG` selects the registered form (1, default, one cycle of latency) or a pass-through form (0).

Top module: `gf3_cube_unit`

## Requirements
- R1: Digit i of a bus sits at bits [2i+1:2i] and is coded 00 = 0, 01 = 1, 10 = 2; when every input digit is legal, no output digit is ever 11.
- R2: For any legal input a, the output equals a^3 reduced modulo x^97 + x^16 + 2, with every output coefficient at index 0..96.
- R3: Positions from 97 to 193 fold through x^97 = 2x^16 + 1; the input x^33 therefore yields 2x^18 + x^2.
- R4: Positions from 194 upward fold through x^194 = x^32 + x^16 + 1; the input x^65 therefore yields x^33 + x^17 + x.
- R5: The base-field constants 0, 1 and 2 (only digit 0 possibly nonzero) cube to themselves.
- R6: With the output register present, out_valid is high exactly one cycle after in_valid is high, and a synchronous active-low reset clears out_valid and out_digits to zero.
- R7: While in_valid is low, out_digits holds its last value regardless of in_digits.
- R8: A term that still lies at or above position 97 after one substitution is folded again; the input x^96 therefore yields 2x^45 + x^94 + x^13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_digits as an operand to be cubed |
| in_digits | input | 2*M | Operand, M base-3 digits of two bits each |
| out_valid | output | 1 | Marks out_digits as a fresh cube |
| out_digits | output | 2*M | Reduced cube, M base-3 digits of two bits each |

## Verification
Single monomials are the sharpest probes: x^33 lands in the single-fold band and exposes the x^97 substitution, x^65 lands at 195 and exposes the x^194 substitution, and x^96 lands at 288, where the result is only right if the second fold is carried out. The constants 0, 1 and 2 separate a correct pass-through of the low band from any stray reduction term, while all-ones and all-twos load every fold path at once. Random operands compared with an independent schoolbook multiply-and-reduce model catch interactions between overlapping fold terms, and idle cycles with changing inputs show that the register holds its value.

// File: rtl/gf3_cube_pkg.sv
// Package: base-3 digit helpers shared by the cubing unit.
// Assumes the two-bit digit code 00=0, 01=1, 10=2; 11 is never formed.
package gf3_cube_pkg;

    typedef logic [1:0] gf3_t;

    // Sum of two digits modulo 3.
    function automatic gf3_t gf3_add(input gf3_t a, input gf3_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

    // Negation, equal to doubling modulo 3: swap the two bits.
    function automatic gf3_t gf3_neg(input gf3_t a);
        return {a[0], a[1]};
    endfunction

endpackage

// File: rtl/gf3_spread.sv
// Module: gf3_spread
// Moves digit i of the operand to position 3i of a wide unreduced vector
// and zeroes every other position. Pure wiring, no logic.
module gf3_spread #(
    parameter int M = 97,
    localparam int NC = 3 * M - 2
) (
    input  logic [2*M-1:0]  op_digits,
    output logic [2*NC-1:0] wide_digits
);
    generate
        for (genvar k = 0; k < NC; k++) begin : g_pos
            if (k % 3 == 0) begin : g_hit
                // Occupied position: carries input digit k/3.
                assign wide_digits[2*k +: 2] = op_digits[2*(k/3) +: 2];
            end else begin : g_gap
                // Unoccupied position: constant zero digit.
                assign wide_digits[2*k +: 2] = 2'b00;
            end
        end
    endgenerate
endmodule

// File: rtl/gf3_fold.sv
// Module: gf3_fold
// Reduces a wide polynomial modulo x^M + x^T + 2 by folding each position
// k >= M onto k-M (weight 1) and k-M+T (weight 2), from the top down, so a
// term that lands at or above M again is folded a second time.
// Assumes 0 < T < M. Purely combinational; after constant folding of the
// empty spread positions it reduces to a shallow adder network.
module gf3_fold
    import gf3_cube_pkg::*;
#(
    parameter int M = 97,
    parameter int T = 16,
    localparam int NC = 3 * M - 2
) (
    input  logic [2*NC-1:0] wide_digits,
    output logic [2*M-1:0]  red_digits
);
    // Fold network: descending walk so folded terms are folded again.
    always_comb begin
        gf3_t acc [NC];
        for (int k = 0; k < NC; k++) begin
            acc[k] = wide_digits[2*k +: 2];
        end
        for (int k = NC - 1; k >= M; k--) begin
            acc[k-M]   = gf3_add(acc[k-M], acc[k]);
            acc[k-M+T] = gf3_add(acc[k-M+T], gf3_neg(acc[k]));
        end
        for (int k = 0; k < M; k++) begin
            red_digits[2*k +: 2] = acc[k];
        end
    end
endmodule

// File: rtl/gf3_cube_core.sv
// Module: gf3_cube_core
// Register-free cube of one GF(3^M) element modulo x^M + x^T + 2:
// spread digits to 3i, then fold the high positions back.
// Assumes legal digit codes on the input.
module gf3_cube_core #(
    parameter int M = 97,
    parameter int T = 16,
    localparam int NC = 3 * M - 2
) (
    input  logic [2*M-1:0] a_digits,
    output logic [2*M-1:0] c_digits
);
    logic [2*NC-1:0] spread_w;

    gf3_spread #(.M(M)) u_spread (
        .op_digits   (a_digits),
        .wide_digits (spread_w)
    );

    gf3_fold #(.M(M), .T(T)) u_fold (
        .wide_digits (spread_w),
        .red_digits  (c_digits)
    );

    // R5 guard: base-field constants are fixed points of cubing.
    always_comb begin
        if (a_digits[2*M-1:2] == '0 && a_digits[1:0] != 2'b11) begin
            a_r5_base_fixed: assert (c_digits == a_digits);
        end
    end
endmodule

// File: rtl/gf3_cube_unit.sv
// Module: gf3_cube_unit (top)
// Cubes a GF(3^M) element modulo x^M + x^T + 2 with a combinational core,
// optionally followed by one register stage with a valid flag (OUT_REG=1).
// The register loads only on in_valid and resets synchronously (active low).
module gf3_cube_unit #(
    parameter int M       = 97,
    parameter int T       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2*M-1:0] in_digits,
    output logic           out_valid,
    output logic [2*M-1:0] out_digits
);
    logic [2*M-1:0] cube_w;

    gf3_cube_core #(.M(M), .T(T)) u_core (
        .a_digits (in_digits),
        .c_digits (cube_w)
    );

    // True when no digit of the bus carries the unused code 11.
    function automatic logic bus_legal(input logic [2*M-1:0] v);
        for (int i = 0; i < M; i++) begin
            if (v[2*i +: 2] == 2'b11) return 1'b0;
        end
        return 1'b1;
    endfunction

    generate
        if (OUT_REG) begin : g_reg
            logic           vld_q;
            logic [2*M-1:0] dat_q;

            // Output stage: capture the cube on in_valid, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) dat_q <= cube_w;
                end
            end

            assign out_valid  = vld_q;
            assign out_digits = dat_q;

            a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_digits));
            a_r2_captures_core: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_digits == $past(cube_w)));
            a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && bus_legal(in_digits)) |=> bus_legal(out_digits));
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_digits = cube_w;

            // R1 guard for the pass-through form.
            always_comb begin
                if (bus_legal(in_digits)) begin
                    a_r1_legal_comb: assert (bus_legal(cube_w));
                end
            end
        end
    endgenerate
endmodule

// File: tb/gf3_cube_unit_bench.sv
`timescale 1ns/1ps
module gf3_cube_unit_bench;
    localparam int M  = 97;
    localparam int T  = 16;
    localparam int W  = 2 * M;

    typedef int poly_t [M];

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_digits = '0;
    logic         out_valid;
    logic [W-1:0] out_digits;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gf3_cube_unit #(.M(M), .T(T), .OUT_REG(1'b1)) u_gf3_cube_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_digits  (in_digits),
        .out_valid  (out_valid),
        .out_digits (out_digits)
    );

    function automatic poly_t unpack_p(input logic [W-1:0] v);
        poly_t p;
        for (int i = 0; i < M; i++) p[i] = int'(v[2*i +: 2]);
        return p;
    endfunction

    function automatic logic [W-1:0] pack_p(input poly_t p);
        logic [W-1:0] v;
        for (int i = 0; i < M; i++) v[2*i +: 2] = 2'(p[i] % 3);
        return v;
    endfunction

    // Schoolbook product reduced with x^97 = 2x^16 + 1.
    function automatic poly_t mulmod(input poly_t a, input poly_t b);
        int   prod [2*M-1];
        poly_t r;
        for (int k = 0; k < 2*M-1; k++) prod[k] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                prod[i+j] = (prod[i+j] + a[i] * b[j]) % 3;
        for (int k = 2*M-2; k >= M; k--) begin
            prod[k-M]   = (prod[k-M] + prod[k]) % 3;
            prod[k-M+T] = (prod[k-M+T] + 2 * prod[k]) % 3;
            prod[k] = 0;
        end
        for (int i = 0; i < M; i++) r[i] = prod[i];
        return r;
    endfunction

    function automatic logic [W-1:0] ref_cube(input logic [W-1:0] v);
        poly_t a;
        a = unpack_p(v);
        return pack_p(mulmod(mulmod(a, a), a));
    endfunction

    function automatic logic [W-1:0] mono(input int idx, input logic [1:0] d);
        logic [W-1:0] v;
        v = '0;
        v[2*idx +: 2] = d;
        return v;
    endfunction

    function automatic bit legal(input logic [W-1:0] v);
        for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check_vec(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive one operand, sample one cycle later away from the edge.
    task automatic apply(input logic [W-1:0] v, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_digits = v;
        @(negedge clk);
        check_bit(out_valid, 1'b1, "R6 valid after operand");
        check_vec(out_digits, exp, req);
        checks++;
        if (!legal(out_digits)) begin
            fails++;
            $display("FAIL R1: illegal digit code in %h expected none", out_digits);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Watchdog: an expired timer counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] keep;
        void'($urandom(32'h0C0BE5ED));

        // R6: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R6 reset valid");
        check_vec(out_digits, '0, "R6 reset data");
        rst_n = 1'b1;

        // R5: base-field constants.
        apply('0, '0, "R5 zero");
        apply(mono(0, 2'b01), mono(0, 2'b01), "R5 one");
        apply(mono(0, 2'b10), mono(0, 2'b10), "R5 two");

        // R3: single fold, x^33 -> 2x^18 + x^2.
        apply(mono(33, 2'b01), mono(18, 2'b10) | mono(2, 2'b01), "R3 x^33");
        // R4: double-degree fold, x^65 -> x^33 + x^17 + x.
        apply(mono(65, 2'b01), mono(33, 2'b01) | mono(17, 2'b01) | mono(1, 2'b01), "R4 x^65");
        // R8: refold, x^96 -> 2x^45 + x^94 + x^13.
        apply(mono(96, 2'b01), mono(45, 2'b10) | mono(94, 2'b01) | mono(13, 2'b01), "R8 x^96");
        // R8: negated top monomial gives the negated result.
        apply(mono(96, 2'b10), mono(45, 2'b01) | mono(94, 2'b10) | mono(13, 2'b10), "R8 2x^96");

        // R2: dense corner operands against the reference.
        v = '0;
        for (int i = 0; i < M; i++) v[2*i +: 2] = 2'b10;
        apply(v, ref_cube(v), "R2 all twos");
        for (int i = 0; i < M; i++) v[2*i +: 2] = 2'b01;
        apply(v, ref_cube(v), "R2 all ones");

        // R7: idle cycles with a changing operand leave the output alone.
        keep = out_digits;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            in_valid = 1'b0;
            for (int i = 0; i < M; i++) in_digits[2*i +: 2] = 2'($urandom_range(0, 2));
            @(negedge clk);
            check_bit(out_valid, 1'b0, "R6 valid low when idle");
            check_vec(out_digits, keep, "R7 hold while idle");
        end

        // R2: constrained random operands.
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < M; i++) v[2*i +: 2] = 2'($urandom_range(0, 2));
            apply(v, ref_cube(v), "R2 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule